// File: doc/BRIEF.md
# Activity Monitor with Watermark Interrupts

The block watches two streams of activity pulses and tells software when either stream gets busier or quieter than programmed limits. One shared timer, fed by a millisecond tick, divides time into sample periods. During a period each channel adds a programmed weight to an accumulator for every activity pulse it sees. When the period closes, the total becomes that channel's raw sample. The sample is then folded into a moving average whose window spans a power-of-two number of periods.

Each closed sample is compared with an upper and a lower watermark, and runs of consecutive crossings are counted against programmable run lengths. The new average is compared with its own pair of watermarks. A matching condition sets a sticky status bit. A global status word summarises which channels have something pending, and a single interrupt line is raised while any enabled status bit is set.

Software reaches all registers over a simple single-cycle read/write bus. Channel 0 sits at 0x1C0 and channel 1 at 0x200. Within a channel the offsets are: 0x00 control, 0x04 upper watermark, 0x08 lower watermark, 0x0C average preload, 0x10 average upper watermark, 0x14 average lower watermark, 0x18 pulse weight, 0x20 current average (read-only), 0x24 status.

Top module: `act_monitor`

## Requirements
- R1: After reset every status register, both averages, the global status word and `irq` read zero.
- R2: The register at 0x004 holds the sample period in ticks minus one. With a value N, a period closes on the (N+1)th `ms_tick` pulse, and nothing is evaluated before that.
- R3: While a channel is running, each cycle with its activity pulse high adds the channel weight (offset 0x18) to the sample. A pulse in the cycle that closes a period still counts toward the closing sample.
- R4: A write to offset 0x0C loads the moving average directly, and the value reads back at offset 0x20.
- R5: At each period close the average becomes avg + ((sample - avg) >>> (K+1)). The difference is signed and the shift is arithmetic. K is the 3-bit field at control bits 12:10.
- R6: Consecutive-above detection is enabled by control bit 30, and its run length minus one sits in control bits 28:26. A sample strictly above the upper watermark (0x04) extends the run, and any other sample clears it. When the run reaches its length, status bit 31 is set and the run restarts.
- R7: Consecutive-below detection works the same way against the lower watermark (0x08, strictly below). It uses enable bit 29, run field bits 25:23 and status bit 30. A sample that is not below clears the run.
- R8: At a period close, a new average strictly above 0x10 sets status bit 29 if control bit 21 is set. A new average strictly below 0x14 sets status bit 28 if control bit 20 is set.
- R9: Status bits are sticky. Writing a one to a status bit clears it, so writing all ones clears them all.
- R10: A status bit is set only while its enable is set. `irq` is the OR over both channels of status bits whose enable is currently set, so clearing an enable drops `irq` without clearing the status.
- R11: The global status word at 0x000 shows channel 0 pending at bit 26 and channel 1 pending at bit 25, where pending means an enabled status bit is set.
- R12: A channel runs only when control bit 31 (master enable) and bit 18 (periodic sampling) are both set. Otherwise its pulses, period closes, average and status are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| act_pulse | input | 2 | Activity pulse per channel |
| ms_tick | input | 1 | Millisecond tick |
| irq | output | 1 | Interrupt request |

## Verification
Most internal state here appears at the ports only at a period close. A wrong accumulator or run counter therefore shows up as a missing, extra or late status bit and `irq` change at the close where the run should complete. That can be several periods after the fault. A wrong average is visible at offset 0x20 right after the close that computes it. Because the average is carried forward, any error keeps spreading into later values and average-watermark events. The bench closes periods with chosen pulse counts and reads status, average, global status and `irq` after every close.

// File: rtl/act_pkg.sv
package act_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned K_W    = 3;
  localparam int unsigned RUN_W  = 3;

  // register offsets inside a channel window
  localparam logic [5:0] OFF_CTRL  = 6'h00;
  localparam logic [5:0] OFF_UPPER = 6'h04;
  localparam logic [5:0] OFF_LOWER = 6'h08;
  localparam logic [5:0] OFF_INIT  = 6'h0C;
  localparam logic [5:0] OFF_AUP   = 6'h10;
  localparam logic [5:0] OFF_ALO   = 6'h14;
  localparam logic [5:0] OFF_WT    = 6'h18;
  localparam logic [5:0] OFF_AVG   = 6'h20;
  localparam logic [5:0] OFF_STS   = 6'h24;

  // control word bit positions
  localparam int unsigned B_K    = 10;
  localparam int unsigned B_PER  = 18;
  localparam int unsigned B_AVLO = 20;
  localparam int unsigned B_AVHI = 21;
  localparam int unsigned B_RLO  = 23;
  localparam int unsigned B_RHI  = 26;
  localparam int unsigned B_CLO  = 29;
  localparam int unsigned B_CHI  = 30;
  localparam int unsigned B_ENB  = 31;

  // status bit positions (contiguous block at the top)
  localparam int unsigned S_LOW  = 28;
  localparam int unsigned GSTAT_TOP = 26;
endpackage

// File: rtl/act_timer.sv
module act_timer #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             per_we,
  input  logic [PER_W-1:0] per_wdata,
  output logic [PER_W-1:0] per_q,
  output logic             period_end
);
  logic [PER_W-1:0] cnt_q, cnt_d;

  always_comb begin
    period_end = tick && (cnt_q >= per_q);
    cnt_d = cnt_q;
    if (tick) cnt_d = period_end ? '0 : cnt_q + PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (per_we) per_q <= per_wdata;
    end
  end
endmodule

// File: rtl/act_channel.sv
module act_channel
  import act_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          period_end,
  input  logic          pulse,
  input  logic          wr_en,
  input  logic [5:0]    off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          pending,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] avg_o,
  output logic [DW-1:0] sts_o
);
  logic [DW-1:0] ctrl_q, up_q, lo_q, aup_q, alo_q, wt_q, avg_q, acc_q;
  logic [DW-1:0] acc_d, avg_d, sample, avg_new;
  logic [3:0]    sts_q, sts_d, set_v, clr_v, en_v;
  logic [RUN_W-1:0] hi_cnt_q, lo_cnt_q, hi_cnt_d, lo_cnt_d;
  logic [RUN_W:0]   hi_next, lo_next, hi_len, lo_len;
  logic [K_W:0]     shamt;
  logic signed [DW:0] diff, step;
  logic active, close, above, below, hi_hit, lo_hit;

  always_comb begin
    active  = ctrl_q[B_ENB] & ctrl_q[B_PER];
    close   = active & period_end;
    sample  = acc_q + (pulse ? wt_q : '0);
    acc_d   = !active ? '0 : (close ? '0 : (pulse ? acc_q + wt_q : acc_q));
    shamt   = {1'b0, ctrl_q[B_K +: K_W]} + (K_W+1)'(1);
    diff    = $signed({1'b0, sample}) - $signed({1'b0, avg_q});
    step    = diff >>> shamt;
    avg_new = avg_q + step[DW-1:0];
    avg_d   = avg_q;
    if (wr_en && off == OFF_INIT) avg_d = wdata;
    else if (close)               avg_d = avg_new;

    above   = sample > up_q;
    below   = sample < lo_q;
    hi_next = {1'b0, hi_cnt_q} + (RUN_W+1)'(1);
    lo_next = {1'b0, lo_cnt_q} + (RUN_W+1)'(1);
    hi_len  = {1'b0, ctrl_q[B_RHI +: RUN_W]} + (RUN_W+1)'(1);
    lo_len  = {1'b0, ctrl_q[B_RLO +: RUN_W]} + (RUN_W+1)'(1);
    hi_hit  = close & above & (hi_next == hi_len);
    lo_hit  = close & below & (lo_next == lo_len);
    hi_cnt_d = hi_cnt_q;
    lo_cnt_d = lo_cnt_q;
    if (!active) begin
      hi_cnt_d = '0;
      lo_cnt_d = '0;
    end else if (close) begin
      hi_cnt_d = (above && !hi_hit) ? hi_next[RUN_W-1:0] : '0;
      lo_cnt_d = (below && !lo_hit) ? lo_next[RUN_W-1:0] : '0;
    end

    en_v  = {ctrl_q[B_CHI], ctrl_q[B_CLO], ctrl_q[B_AVHI], ctrl_q[B_AVLO]};
    set_v = {hi_hit, lo_hit, close & (avg_new > aup_q), close & (avg_new < alo_q)} & en_v;
    clr_v = (wr_en && off == OFF_STS) ? wdata[DW-1:S_LOW] : 4'b0;
    sts_d = (sts_q & ~clr_v) | set_v;
    pending = |(sts_q & en_v);
  end

  always_comb begin
    unique case (off)
      OFF_CTRL:  rdata = ctrl_q;
      OFF_UPPER: rdata = up_q;
      OFF_LOWER: rdata = lo_q;
      OFF_AUP:   rdata = aup_q;
      OFF_ALO:   rdata = alo_q;
      OFF_WT:    rdata = wt_q;
      OFF_AVG:   rdata = avg_q;
      OFF_STS:   rdata = sts_o;
      default:   rdata = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign avg_o  = avg_q;
  assign sts_o  = {sts_q, {S_LOW{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; up_q <= '0; lo_q <= '0; aup_q <= '0; alo_q <= '0;
      wt_q <= '0; avg_q <= '0; acc_q <= '0; sts_q <= '0;
      hi_cnt_q <= '0; lo_cnt_q <= '0;
    end else begin
      if (wr_en && off == OFF_CTRL)  ctrl_q <= wdata;
      if (wr_en && off == OFF_UPPER) up_q   <= wdata;
      if (wr_en && off == OFF_LOWER) lo_q   <= wdata;
      if (wr_en && off == OFF_AUP)   aup_q  <= wdata;
      if (wr_en && off == OFF_ALO)   alo_q  <= wdata;
      if (wr_en && off == OFF_WT)    wt_q   <= wdata;
      avg_q    <= avg_d;
      acc_q    <= acc_d;
      sts_q    <= sts_d;
      hi_cnt_q <= hi_cnt_d;
      lo_cnt_q <= lo_cnt_d;
    end
  end
endmodule

// File: rtl/act_monitor.sv
module act_monitor
  import act_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned PER_W   = 16,
  parameter logic [11:0] CH0_BASE = 12'h1C0,
  parameter logic [11:0] CH1_BASE = 12'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NUM_CH-1:0] act_pulse,
  input  logic              ms_tick,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_GSTAT = '0;
  localparam logic [ADDR_W-1:0] A_PER   = ADDR_W'(4);

  logic [PER_W-1:0] per_q;
  logic period_end, per_we;
  logic [NUM_CH-1:0] hit, pend;
  logic [NUM_CH-1:0][DW-1:0] ch_rd, ch_ctrl, ch_avg, ch_sts;
  logic [DW-1:0] gstat;

  assign per_we = bus_sel & bus_we & (bus_addr == A_PER);

  act_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .per_we(per_we),
    .per_wdata(bus_wdata[PER_W-1:0]), .per_q(per_q), .period_end(period_end)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [11:0] BASE = (g == 0) ? CH0_BASE : CH1_BASE;
    assign hit[g] = (bus_addr[ADDR_W-1:6] == BASE[ADDR_W-1:6]);
    act_channel u_ch (
      .clk(clk), .rst_n(rst_n), .period_end(period_end), .pulse(act_pulse[g]),
      .wr_en(bus_sel & bus_we & hit[g]), .off(bus_addr[5:0]), .wdata(bus_wdata),
      .rdata(ch_rd[g]), .pending(pend[g]), .ctrl_o(ch_ctrl[g]),
      .avg_o(ch_avg[g]), .sts_o(ch_sts[g])
    );
  end

  always_comb begin
    gstat = '0;
    for (int i = 0; i < NUM_CH; i++) gstat[GSTAT_TOP-i] = pend[i];
    bus_rdata = '0;
    if (bus_addr == A_GSTAT)    bus_rdata = gstat;
    else if (bus_addr == A_PER) bus_rdata = DW'(per_q);
    else
      for (int i = 0; i < NUM_CH; i++)
        if (hit[i]) bus_rdata = ch_rd[i];
  end

  assign irq = |pend;
endmodule

// File: rtl/act_monitor_chk.sv
module act_monitor_chk
  import act_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter logic [11:0] CH0_BASE = 12'h1C0
) (
  input logic clk,
  input logic rst_n,
  input logic bus_sel,
  input logic bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic period_end,
  input logic irq,
  input logic [NUM_CH-1:0][DW-1:0] ch_ctrl,
  input logic [NUM_CH-1:0][DW-1:0] ch_avg,
  input logic [NUM_CH-1:0][DW-1:0] ch_sts
);
  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ch_sts[0] != '0 || ch_sts[1] != '0));

  // R12
  idle_avg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_ctrl[0][B_ENB] && !(bus_sel && bus_we)) |=> $stable(ch_avg[0]));

  // R6
  chi_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_sts[0][31]) |-> $past(period_end));

  // R8
  ahi_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_sts[1][29]) |-> $past(period_end));

  // R9
  sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == ADDR_W'(CH0_BASE + 12'h24) &&
     bus_wdata == '1 && !period_end) |=> (ch_sts[0] == '0));
endmodule

bind act_monitor act_monitor_chk #(.ADDR_W(ADDR_W), .CH0_BASE(CH0_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .period_end(period_end),
  .irq(irq), .ch_ctrl(ch_ctrl), .ch_avg(ch_avg), .ch_sts(ch_sts)
);

// File: tb/act_monitor_test.sv
module act_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] C0 = 12'h1C0, C1 = 12'h200;
  localparam logic [31:0] ENB = 32'h8000_0000, PER = 32'h0004_0000;
  localparam logic [31:0] CHI = 32'h4000_0000, CLO = 32'h2000_0000;
  localparam logic [31:0] AVHI = 32'h0020_0000, AVLO = 32'h0010_0000;

  logic clk = 0, rst_n = 0, bus_sel = 0, bus_we = 0, ms_tick = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [1:0]  act_pulse = '0;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  longint exp_avg0, exp_avg1;

  act_monitor uut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .act_pulse(act_pulse), .ms_tick(ms_tick), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint nxt(longint a, longint s, int k);
    longint d = s - a;
    d = d >>> (k + 1);
    return (a + d) & 64'hFFFF_FFFF;
  endfunction

  task automatic check(string tag, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 check(tag, bus_rdata, exp);
    bus_sel = 0;
  endtask

  task automatic pulses(int ch, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); act_pulse[ch] = 1;
      @(negedge clk); act_pulse[ch] = 0;
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ms_tick = 1;
      @(negedge clk); ms_tick = 0;
    end
  endtask

  // one full period (period register = 1, so two ticks) on channel ch
  task automatic period(int ch, int n);
    pulses(ch, n);
    ticks(2);
  endtask

  task automatic t_reset;
    rd_chk("R1 ch0 status", C0 + 12'h24, 0);
    rd_chk("R1 ch0 avg", C0 + 12'h20, 0);
    rd_chk("R1 ch1 avg", C1 + 12'h20, 0);
    rd_chk("R1 gstat", 12'h000, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_setup;
    wr(12'h004, 1);
    rd_chk("R2 period readback", 12'h004, 1);
    wr(C0 + 12'h18, 10);
    wr(C0 + 12'h04, 100);
    wr(C0 + 12'h08, 20);
    wr(C0 + 12'h10, 32'hFFFF_FFFF);
    wr(C0 + 12'h14, 0);
    wr(C0 + 12'h0C, 1000);
    exp_avg0 = 1000;
    rd_chk("R4 preload", C0 + 12'h20, 1000);
  endtask

  task automatic t_above;
    wr(C0, ENB | PER | (1 << 10) | (2 << 23) | (0 << 26) | CHI);
    pulses(0, 15);
    ticks(1);
    rd_chk("R2 no close after one tick", C0 + 12'h24, 0);
    ticks(1);
    exp_avg0 = nxt(exp_avg0, 150, 1);
    rd_chk("R6 above status", C0 + 12'h24, 32'h8000_0000);
    check("R10 irq set", irq, 1);
    rd_chk("R11 gstat ch0", 12'h000, 32'h0400_0000);
    rd_chk("R5 avg 787", C0 + 12'h20, 32'(exp_avg0));
    check("R5 model", exp_avg0, 787);
    wr(C0 + 12'h24, 32'hFFFF_FFFF);
    rd_chk("R9 cleared", C0 + 12'h24, 0);
    check("R9 irq low", irq, 0);
  endtask

  task automatic t_below;
    int s[6] = '{0, 0, 50, 0, 0, 0};
    wr(C0, ENB | PER | (1 << 10) | (2 << 23) | CHI | CLO);
    for (int i = 0; i < 6; i++) begin
      period(0, s[i] / 10);
      exp_avg0 = nxt(exp_avg0, s[i], 1);
      rd_chk($sformatf("R7 below step %0d", i), C0 + 12'h24,
             (i == 5) ? 32'h4000_0000 : 32'h0);
    end
    rd_chk("R5 avg after below run", C0 + 12'h20, 32'(exp_avg0));
    check("R10 irq below", irq, 1);
    wr(C0 + 12'h24, 32'hFFFF_FFFF);
  endtask

  task automatic t_avg;
    int s[5] = '{400, 1000, 0, 0, 0};
    logic [31:0] e[5] = '{0, 32'h2000_0000, 0, 0, 32'h1000_0000};
    wr(C0, ENB | PER | (1 << 10) | AVHI | AVLO);
    wr(C0 + 12'h0C, 400);
    wr(C0 + 12'h10, 500);
    wr(C0 + 12'h14, 300);
    exp_avg0 = 400;
    for (int i = 0; i < 5; i++) begin
      period(0, s[i] / 10);
      exp_avg0 = nxt(exp_avg0, s[i], 1);
      rd_chk($sformatf("R8 avg wmark step %0d (R10 gating)", i), C0 + 12'h24, e[i]);
      rd_chk($sformatf("R5 avg step %0d", i), C0 + 12'h20, 32'(exp_avg0));
      if (e[i] != 0) wr(C0 + 12'h24, 32'hFFFF_FFFF);
    end
    check("R8 final avg 231", exp_avg0, 231);
    wr(C0, 0);
  endtask

  task automatic t_ch1;
    wr(C1 + 12'h18, 3);
    wr(C1 + 12'h04, 5);
    wr(C1 + 12'h10, 32'hFFFF_FFFF);
    wr(C1, ENB | PER | CHI);
    exp_avg1 = 0;
    pulses(1, 1);
    ticks(1);
    @(negedge clk); act_pulse[1] = 1; ms_tick = 1;
    @(negedge clk); act_pulse[1] = 0; ms_tick = 0;
    exp_avg1 = nxt(exp_avg1, 6, 0);
    rd_chk("R3 weight and close-cycle pulse", C1 + 12'h24, 32'h8000_0000);
    rd_chk("R5 K=0 avg", C1 + 12'h20, 32'(exp_avg1));
    rd_chk("R11 gstat ch1", 12'h000, 32'h0200_0000);
    check("R10 irq ch1", irq, 1);
    wr(C1, ENB | PER);
    check("R10 irq masked", irq, 0);
    rd_chk("R10 status kept", C1 + 12'h24, 32'h8000_0000);
    wr(C1 + 12'h24, 32'h8000_0000);
    rd_chk("R9 single-bit clear", C1 + 12'h24, 0);
  endtask

  task automatic t_disable;
    wr(C1, PER | CHI);
    period(1, 10);
    rd_chk("R12 ch1 avg held", C1 + 12'h20, 32'(exp_avg1));
    rd_chk("R12 ch1 status held", C1 + 12'h24, 0);
    wr(C1, ENB | CHI);
    period(1, 10);
    rd_chk("R12 no periodic, avg held", C1 + 12'h20, 32'(exp_avg1));
    rd_chk("R12 ch0 avg held", C0 + 12'h20, 32'(exp_avg0));
    check("R12 irq low", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_setup();
    t_above();
    t_below();
    t_avg();
    t_ch1();
    t_disable();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule